// File: doc/BRIEF.md
# Interval Timer with Wrapping Comparator

This block keeps a free-running time base that advances by one on every clock. Software sees a slower view of it: the visible count is the base divided by four, taken as the base shifted right by a parameterised amount. A narrow compare value written by software is turned into a full-width deadline. The written value is shifted left by the same amount and spliced into the low window of the current base. If the resulting deadline is not at least a margin of base ticks ahead of the current base, one window period is added to it.

When the base reaches the deadline, a level interrupt is raised. It stays up until software pulses a clear strobe or writes a new compare value. Each write arms the comparator once, so one write produces at most one interrupt. Clock generation and interrupt routing sit outside the block.

Top module: `interval_timer`

## Requirements
- R1: After reset the base is zero, `irq` is low, and no interrupt can occur before the first compare write (the deadline resets to all ones and the comparator is disarmed).
- R2: The base increments by one every clock after reset, and `count_out` always equals the base shifted right by SHIFT (default 2).
- R3: A write with `wr_en` high loads the deadline with the current base, whose low CMP_W+SHIFT bits are replaced by `wr_val` followed by SHIFT zero bits.
- R4: If that spliced value is less than the current base plus MARGIN, the stored deadline is the spliced value plus 2^(CMP_W+SHIFT). The deadline is then always between 1 and 2^(CMP_W+SHIFT)+MARGIN-1 ticks ahead of the base at the write.
- R5: `irq` rises in the cycle that follows the first clock edge at which the armed comparator sees base >= deadline. For a write accepted at base b with deadline D, that is D-b clock edges after the write edge.
- R6: `irq` holds until `clr` is sampled high and then drops one cycle later. It does not return without a new write. If `clr` and a match arrive at the same edge, the match wins and `irq` goes high.
- R7: A write clears `irq` at the next edge and re-arms the comparator, taking priority over both `clr` and a match.
- R8: The roll-forward test is strict. A spliced value equal to base+MARGIN is kept as it is, giving a latency of exactly MARGIN edges. A spliced value equal to base+MARGIN-1 is rolled forward, giving a latency of MARGIN-1+2^(CMP_W+SHIFT) edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the base advances on each rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Compare write strobe |
| wr_val | input | CMP_W | Compare value written by software |
| clr | input | 1 | Interrupt clear strobe |
| count_out | output | BASE_W-SHIFT | Visible counter, base >> SHIFT |
| irq | output | 1 | Level interrupt |

## Verification
The bench shrinks the window to 10 bits and the margin to 16, so roll-forward cases finish within about a thousand cycles. It places the spliced value exactly at base+MARGIN and at one tick less. A comparison that is off by one, or that is not strict, shifts the measured latency by a full window period. It writes a low value below the current base's window position, which a design without roll-forward would answer with an immediate interrupt. It also lines up a clear with the match edge, writes while the interrupt is high, and waits after a clear to catch a comparator that fires again at every cycle at or past the deadline.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int unsigned MAXW = 64;
  typedef logic [MAXW-1:0] word_t;

  // mask of the low 'win' bits
  function automatic word_t win_mask(input int unsigned win);
    if (win >= MAXW) return '1;
    return (word_t'(1) << win) - word_t'(1);
  endfunction

  // place the shifted compare value into the low window of the base
  function automatic word_t splice_deadline(input word_t base, input word_t wval,
                                            input int unsigned shift, input int unsigned win);
    word_t m;
    m = win_mask(win);
    return (base & ~m) | ((wval << shift) & m);
  endfunction

  // push a deadline one window ahead when it is too close or behind
  function automatic word_t roll_forward(input word_t cand, input word_t base, input word_t margin,
                                         input int unsigned win, input word_t bmask);
    if ((cand & bmask) < ((base + margin) & bmask))
      return (cand + (word_t'(1) << win)) & bmask;
    return cand & bmask;
  endfunction
endpackage

// File: rtl/itmr_base.sv
module itmr_base #(
  parameter int unsigned BASE_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [BASE_W-1:0] base
);
  always_ff @(posedge clk) begin
    if (!rst_n) base <= '0;
    else        base <= base + 1'b1;
  end

  // R2
  base_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && $past(rst_n) |-> base == $past(base) + 1'b1);
endmodule

// File: rtl/itmr_deadline.sv
module itmr_deadline
  import itmr_pkg::*;
#(
  parameter int unsigned BASE_W = 64,
  parameter int unsigned CMP_W  = 32,
  parameter int unsigned SHIFT  = 2,
  parameter int unsigned MARGIN = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CMP_W-1:0]  wr_val,
  input  logic [BASE_W-1:0] base,
  output logic [BASE_W-1:0] deadline
);
  localparam int unsigned WIN   = CMP_W + SHIFT;
  localparam word_t       BMASK = win_mask(BASE_W);
  localparam logic [BASE_W-1:0] WMASK = BASE_W'(win_mask(WIN));
  localparam logic [BASE_W-1:0] LIM   = BASE_W'((word_t'(1) << WIN) + word_t'(MARGIN));

  word_t base_w, val_w, cand, rolled;

  always_comb begin
    base_w = '0;
    base_w[BASE_W-1:0] = base;
    val_w = '0;
    val_w[CMP_W-1:0] = wr_val;
    cand   = splice_deadline(base_w, val_w, SHIFT, WIN) & BMASK;
    rolled = roll_forward(cand, base_w, word_t'(MARGIN), WIN, BMASK);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     deadline <= '1;
    else if (wr_en) deadline <= rolled[BASE_W-1:0];
  end

  // R3
  splice_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (deadline & WMASK) == (BASE_W'($past(wr_val)) << SHIFT));
  // R4
  ahead_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((deadline - $past(base)) != '0) && ((deadline - $past(base)) < LIM));
endmodule

// File: rtl/itmr_alarm.sv
module itmr_alarm #(
  parameter int unsigned BASE_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              clr,
  input  logic [BASE_W-1:0] base,
  input  logic [BASE_W-1:0] deadline,
  output logic              fire,
  output logic              irq
);
  logic armed;

  assign fire = armed && (base >= deadline);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      irq   <= 1'b0;
    end else if (wr_en) begin
      armed <= 1'b1;
      irq   <= 1'b0;
    end else if (fire) begin
      armed <= 1'b0;
      irq   <= 1'b1;
    end else if (clr) begin
      irq   <= 1'b0;
    end
  end

  // R5
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(fire));
  // R6
  clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !wr_en && !fire |=> !irq);
  // R6
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !clr && !wr_en |=> irq);
  // R7
  wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !irq);
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int unsigned BASE_W = 64,
  parameter int unsigned CMP_W  = 32,
  parameter int unsigned SHIFT  = 2,
  parameter int unsigned MARGIN = 1000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [CMP_W-1:0]        wr_val,
  input  logic                    clr,
  output logic [BASE_W-SHIFT-1:0] count_out,
  output logic                    irq
);
  logic [BASE_W-1:0] base;
  logic [BASE_W-1:0] deadline;
  logic              fire;

  itmr_base #(.BASE_W(BASE_W)) u_base (
    .clk(clk), .rst_n(rst_n), .base(base));

  itmr_deadline #(.BASE_W(BASE_W), .CMP_W(CMP_W), .SHIFT(SHIFT), .MARGIN(MARGIN)) u_dl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_val(wr_val),
    .base(base), .deadline(deadline));

  itmr_alarm #(.BASE_W(BASE_W)) u_alarm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .clr(clr),
    .base(base), .deadline(deadline), .fire(fire), .irq(irq));

  assign count_out = base[BASE_W-1:SHIFT];

  // R1
  no_early_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !irq);
endmodule

// File: tb/interval_timer_tb_top.sv
module interval_timer_tb_top;
  localparam int BW = 20, CW = 8, SH = 2, MG = 16;
  localparam longint WINP = 1024;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, clr = 1'b0;
  logic [CW-1:0] wr_val = '0;
  logic [BW-SH-1:0] count_out;
  logic irq;

  always #5 clk = ~clk;

  interval_timer #(.BASE_W(BW), .CMP_W(CW), .SHIFT(SH), .MARGIN(MG)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_val(wr_val), .clr(clr),
    .count_out(count_out), .irq(irq));

  int vectors = 0, fails = 0;
  typedef struct { longint lat; string tag; } exp_t;
  exp_t q[$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model written from the requirements
  longint mb, md;
  bit ma, mi;
  function automatic longint ref_deadline(input longint b, input longint v);
    longint d;
    d = (b / WINP) * WINP + v * 4;
    if (d < b + MG) d += WINP;
    return d % (64'd1 << BW);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mb <= 0; md <= (64'd1 << BW) - 1; ma <= 0; mi <= 0;
    end else begin
      mb <= (mb + 1) % (64'd1 << BW);
      if (wr_en) begin md <= ref_deadline(mb, longint'(wr_val)); ma <= 1; mi <= 0; end
      else if (ma && mb >= md) begin mi <= 1; ma <= 0; end
      else if (clr) mi <= 0;
    end
  end

  // monitor: edges since last write, per-cycle compare, latency scoreboard
  longint edges = 0;
  bit irq_seen = 0;
  always @(posedge clk) edges <= wr_en ? 0 : edges + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      chk(longint'(count_out) == (mb >> SH), "R2 count", longint'(count_out), mb >> SH);
      chk(irq == mi, "R5 irq level", longint'(irq), longint'(mi));
      if (irq && !irq_seen && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(edges == e.lat, e.tag, edges, e.lat);
      end
      irq_seen = irq;
    end
  end

  // driver
  task automatic arm(input longint v, input longint lat, input string tag);
    exp_t e;
    e.lat = lat; e.tag = tag;
    q.push_back(e);
    wr_val = CW'(v); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_irq(input string tag);
    for (int i = 0; i < 3000 && !irq; i++) @(negedge clk);
    chk(irq == 1'b1, tag, longint'(irq), 1);
  endtask

  task automatic wait_low(input longint lo, input longint hi, input int modv);
    while ((mb % WINP) < lo || (mb % WINP) > hi || ((mb + modv) % 4) != 0) @(negedge clk);
  endtask

  initial begin
    longint b, t;
    repeat (4) @(negedge clk);
    chk(count_out == '0, "R1 count at reset", longint'(count_out), 0);
    chk(irq == 1'b0, "R1 irq at reset", longint'(irq), 0);
    rst_n = 1'b1;
    repeat (300) @(negedge clk);
    chk(irq == 1'b0, "R1 no irq before write", longint'(irq), 0);

    // R3 plain future deadline, R6 hold and clear
    wait_low(100, 400, 0);
    b = mb; t = ((b % WINP) + 200) / 4;
    arm(t, (b / WINP) * WINP + t * 4 - b, "R3 latency");
    wait_irq("R5 fired");
    repeat (5) @(negedge clk);
    chk(irq == 1'b1, "R6 hold", longint'(irq), 1);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    chk(irq == 1'b0, "R6 clear", longint'(irq), 0);
    repeat (50) @(negedge clk);
    chk(irq == 1'b0, "R6 no refire", longint'(irq), 0);

    // R4 spliced value behind the base
    wait_low(600, 900, 0);
    b = mb;
    arm(10, (b / WINP + 1) * WINP + 40 - b, "R4 roll latency");
    wait_irq("R4 fired");

    // R7 write while irq is high
    repeat (3) @(negedge clk);
    b = mb;
    arm(255, ref_deadline(b, 255) - b, "R7 rearm latency");
    chk(irq == 1'b0, "R7 write clears", longint'(irq), 0);
    wait_irq("R7 fired");

    // R8 boundary: exactly margin ahead, kept
    wait_low(100, 800, MG);
    b = mb;
    arm(((b + MG) % WINP) / 4, MG, "R8 equal margin");
    wait_irq("R8 fired equal");

    // R8 boundary: one tick short, rolled
    wait_low(100, 800, MG - 1);
    b = mb;
    arm(((b + MG - 1) % WINP) / 4, MG - 1 + WINP, "R8 short margin");
    wait_irq("R8 fired short");

    // R6 clear and match on the same edge: match wins
    wait_low(100, 600, 0);
    b = mb; t = ((b % WINP) + 64) / 4;
    arm(t, (b / WINP) * WINP + t * 4 - b, "R6 set-wins latency");
    repeat (int'((b / WINP) * WINP + t * 4 - b) - 1) @(negedge clk);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    chk(irq == 1'b1, "R6 set wins over clr", longint'(irq), 1);

    repeat (10) @(negedge clk);
    chk(q.size() == 0, "R5 all expected interrupts seen", q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R5 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule